// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block builds full-duplex flow-control (pause) frames and places them in a transmit byte stream that carries one byte per clock. It sits between the user transmit source and the downstream path that adds preamble, start delimiter and frame check sequence. A pause frame is never spliced into a user frame. A pending request waits until the user frame in flight has sent its last byte. The pause frame then goes out before the next user frame, and the user side is held off with its ready signal.

A request to stop the link partner (XOFF) can come from three places: the receive buffer's section-empty threshold flag, a generate bit driven from configuration, and an external request pin. A request to resume (XON) comes from a configuration bit or a pin. An XOFF frame carries the configured pause quanta. An XON frame carries a quanta of zero. After each XOFF frame a holdoff counter runs for the configured number of 512-bit-time slots (64 clocks each), and no new XOFF is accepted until it expires. A level-held source therefore produces evenly spaced XOFF frames. A global flow-control enable gates the whole function.

Top module: `pause_frame_gen`

## Requirements
- R1: Bytes 0 to 5 of every pause frame (byte 0 sent first) are 0x01, 0x80, 0xC2, 0x00, 0x00, 0x01.
- R2: Bytes 6 to 11 carry the station address, least significant byte first: addr_lo[7:0], addr_lo[15:8], addr_lo[23:16], addr_lo[31:24], addr_hi[7:0], addr_hi[15:8].
- R3: Bytes 12 to 15 are 0x88, 0x08, 0x00, 0x01. A pause frame is exactly 60 bytes on 60 consecutive clocks with tx_valid and tx_pause high, and tx_last is high only on byte 59.
- R4: In an XOFF frame, byte 16 is pause_quanta[15:8] and byte 17 is pause_quanta[7:0]. In an XON frame both bytes are 0x00.
- R5: Bytes 18 to 59 are all 0x00.
- R6: A request that arrives during a user frame is held until that frame's last byte has been accepted. While a pause frame is sent, and in the cycle before it, usr_ready is low. User bytes pass to tx_data unchanged with tx_pause low.
- R7: A one-cycle XOFF request on any one of xoff_fifo, xoff_cfg or xoff_pin produces one XOFF frame.
- R8: A one-cycle request on xon_cfg or xon_pin produces one XON frame.
- R9: If XON and XOFF are requested in the same cycle, an XOFF frame is sent.
- R10: Loading holdoff_quanta = H makes the first bytes of consecutive XOFF frames from a held XOFF source at least max(60, 64*H) clocks apart and at most max(61, 64*H+2) clocks apart. An XOFF request made while the holdoff counter is non-zero is dropped.
- R11: While fc_enable is low, all requests are ignored and any pending request is dropped. No pause frame starts, even after fc_enable is raised again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_enable | input | 1 | Flow-control function enable |
| addr_lo | input | 32 | Station address, lower 32 bits |
| addr_hi | input | 16 | Station address, upper 16 bits |
| pause_quanta | input | 16 | Quanta value placed in XOFF frames |
| holdoff_quanta | input | 16 | Minimum XOFF spacing, in 64-clock slots |
| xoff_fifo | input | 1 | Receive buffer section-empty flag (XOFF request) |
| xoff_cfg | input | 1 | Configuration XOFF generate bit |
| xoff_pin | input | 1 | External XOFF request |
| xon_cfg | input | 1 | Configuration XON generate bit |
| xon_pin | input | 1 | External XON request |
| usr_valid | input | 1 | User byte valid |
| usr_data | input | 8 | User byte |
| usr_last | input | 1 | Last byte of user frame |
| usr_ready | output | 1 | User byte accepted this cycle when valid |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Last byte of output frame |
| tx_pause | output | 1 | Output byte belongs to a pause frame |

## Verification
The assertions check on every cycle that usr_ready stays low through a pause frame, that no pause frame starts while fc_enable is low or directly after a non-final user byte, that an XOFF frame starts only with the holdoff counter at zero, that XOFF wins over XON, and that each pause frame opens with the group address byte and is followed by an idle or user cycle. The byte-by-byte content for a sweep of addresses and quanta values, the spacing of held XOFF requests across several holdoff settings, and the dropping of requests while the function is disabled can only be shown by the bench's scenarios.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int QUANTA_W  = 16;
  localparam int ADDR_W    = 48;
  localparam int HDR_BYTES = 18;
  localparam logic [47:0] GROUP_DA  = 48'h0180_C200_0001;
  localparam logic [31:0] TYPE_OPC  = 32'h8808_0001;

  // Byte idx of a pause frame; station address is sent least significant byte first.
  function automatic logic [7:0] frame_byte(input int unsigned idx,
                                            input logic [ADDR_W-1:0] sa,
                                            input logic [QUANTA_W-1:0] q);
    logic [7:0] b;
    if (idx < 6)
      b = GROUP_DA[8*(5-idx) +: 8];
    else if (idx < 12)
      b = sa[8*(idx-6) +: 8];
    else if (idx < 16)
      b = TYPE_OPC[8*(15-idx) +: 8];
    else if (idx == 16)
      b = q[15:8];
    else if (idx == 17)
      b = q[7:0];
    else
      b = 8'h00;
    return b;
  endfunction
endpackage

// File: rtl/pfg_request.sv
module pfg_request
  import pfg_pkg::*;
#(
  parameter int SLOT_CLKS = 64,
  parameter int N_XOFF    = 3,
  parameter int N_XON     = 2,
  localparam int HOLD_W   = QUANTA_W + $clog2(SLOT_CLKS)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_enable,
  input  logic [N_XOFF-1:0]   xoff_src,
  input  logic [N_XON-1:0]    xon_src,
  input  logic [QUANTA_W-1:0] holdoff_quanta,
  input  logic                start_pause,
  output logic                pend_valid,
  output logic                pend_xoff,
  output logic                hold_zero
);
  function automatic logic [HOLD_W-1:0] hold_clocks(input logic [QUANTA_W-1:0] h);
    return HOLD_W'(h) * HOLD_W'(SLOT_CLKS);
  endfunction

  logic [HOLD_W-1:0] hold_cnt;
  logic xoff_req, xon_req, start_xoff;

  assign start_xoff = start_pause & pend_xoff;
  assign hold_zero  = (hold_cnt == '0);
  assign xoff_req   = fc_enable & (|xoff_src) & hold_zero & ~start_xoff;
  assign xon_req    = fc_enable & (|xon_src);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_xoff  <= 1'b0;
    end else if (!fc_enable) begin
      pend_valid <= 1'b0;
      pend_xoff  <= 1'b0;
    end else if (xoff_req) begin
      pend_valid <= 1'b1;
      pend_xoff  <= 1'b1;
    end else if (xon_req && !(pend_valid && pend_xoff && !start_pause)) begin
      pend_valid <= 1'b1;
      pend_xoff  <= 1'b0;
    end else if (start_pause) begin
      pend_valid <= 1'b0;
      pend_xoff  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (start_xoff)
      hold_cnt <= hold_clocks(holdoff_quanta);
    else if (!hold_zero)
      hold_cnt <= hold_cnt - 1'b1;
  end
endmodule

// File: rtl/pfg_framer.sv
module pfg_framer
  import pfg_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  localparam int IDX_W      = $clog2(FRAME_BYTES)
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_pause,
  input  logic                start_xoff,
  input  logic [ADDR_W-1:0]   station,
  input  logic [QUANTA_W-1:0] pause_quanta,
  output logic                busy,
  output logic [7:0]          pbyte,
  output logic                plast
);
  logic [IDX_W-1:0]    idx;
  logic [ADDR_W-1:0]   sa_q;
  logic [QUANTA_W-1:0] q_q;

  assign plast = busy && (idx == IDX_W'(FRAME_BYTES-1));
  assign pbyte = frame_byte(int'(unsigned'(idx)), sa_q, q_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      sa_q <= '0;
      q_q  <= '0;
    end else if (start_pause) begin
      busy <= 1'b1;
      idx  <= '0;
      sa_q <= station;
      q_q  <= start_xoff ? pause_quanta : '0;
    end else if (busy) begin
      if (plast) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfg_merge.sv
module pfg_merge (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fc_enable,
  input  logic       pend_valid,
  input  logic       busy,
  input  logic [7:0] pbyte,
  input  logic       plast,
  input  logic       usr_valid,
  input  logic [7:0] usr_data,
  input  logic       usr_last,
  output logic       usr_ready,
  output logic       start_pause,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       tx_pause
);
  logic in_frame, usr_take;

  assign start_pause = pend_valid & fc_enable & ~busy & ~in_frame;
  assign usr_ready   = ~busy & ~start_pause;
  assign usr_take    = usr_valid & usr_ready;

  assign tx_valid = busy | usr_take;
  assign tx_data  = busy ? pbyte : usr_data;
  assign tx_last  = busy ? plast : (usr_take & usr_last);
  assign tx_pause = busy;

  always_ff @(posedge clk) begin
    if (!rst_n)
      in_frame <= 1'b0;
    else if (usr_take)
      in_frame <= ~usr_last;
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
#(
  parameter int SLOT_CLKS   = 64,
  parameter int FRAME_BYTES = 60
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fc_enable,
  input  logic [31:0] addr_lo,
  input  logic [15:0] addr_hi,
  input  logic [15:0] pause_quanta,
  input  logic [15:0] holdoff_quanta,
  input  logic        xoff_fifo,
  input  logic        xoff_cfg,
  input  logic        xoff_pin,
  input  logic        xon_cfg,
  input  logic        xon_pin,
  input  logic        usr_valid,
  input  logic [7:0]  usr_data,
  input  logic        usr_last,
  output logic        usr_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        tx_pause
);
  logic pend_valid, pend_xoff, hold_zero;
  logic start_pause, start_xoff, busy, plast;
  logic [7:0] pbyte;

  assign start_xoff = start_pause & pend_xoff;

  pfg_request #(.SLOT_CLKS(SLOT_CLKS), .N_XOFF(3), .N_XON(2)) u_req (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
    .xoff_src({xoff_pin, xoff_cfg, xoff_fifo}),
    .xon_src({xon_pin, xon_cfg}),
    .holdoff_quanta(holdoff_quanta),
    .start_pause(start_pause),
    .pend_valid(pend_valid), .pend_xoff(pend_xoff), .hold_zero(hold_zero)
  );

  pfg_framer #(.FRAME_BYTES(FRAME_BYTES)) u_frm (
    .clk(clk), .rst_n(rst_n),
    .start_pause(start_pause), .start_xoff(start_xoff),
    .station({addr_hi, addr_lo}), .pause_quanta(pause_quanta),
    .busy(busy), .pbyte(pbyte), .plast(plast)
  );

  pfg_merge u_mrg (
    .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
    .pend_valid(pend_valid), .busy(busy), .pbyte(pbyte), .plast(plast),
    .usr_valid(usr_valid), .usr_data(usr_data), .usr_last(usr_last),
    .usr_ready(usr_ready), .start_pause(start_pause),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_pause(tx_pause)
  );
endmodule

// File: rtl/pfg_checker.sv
module pfg_checker (
  input logic clk,
  input logic rst_n,
  input logic fc_enable,
  input logic xoff_any,
  input logic xon_any,
  input logic usr_valid,
  input logic usr_last,
  input logic usr_ready,
  input logic tx_pause,
  input logic tx_last,
  input logic [7:0] tx_data,
  input logic busy,
  input logic start_pause,
  input logic pend_valid,
  input logic pend_xoff,
  input logic hold_zero
);
  p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !usr_ready);

  p_no_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_valid && usr_ready && !usr_last) |=> !start_pause);

  p_group_da_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> (tx_data == 8'h01));

  p_frame_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pause && tx_last) |=> !tx_pause);

  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_enable |-> !start_pause);

  p_holdoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pause && pend_xoff) |-> hold_zero);

  p_xoff_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_enable && xoff_any && xon_any && hold_zero && !start_pause)
      |=> (pend_valid && pend_xoff));
endmodule

bind pause_frame_gen pfg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fc_enable(fc_enable),
  .xoff_any(xoff_fifo | xoff_cfg | xoff_pin),
  .xon_any(xon_cfg | xon_pin),
  .usr_valid(usr_valid), .usr_last(usr_last), .usr_ready(usr_ready),
  .tx_pause(tx_pause), .tx_last(tx_last), .tx_data(tx_data),
  .busy(busy), .start_pause(start_pause),
  .pend_valid(pend_valid), .pend_xoff(pend_xoff), .hold_zero(hold_zero)
);

// File: tb/pause_frame_gen_tb.sv
module pause_frame_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fc_enable = 1'b1;
  logic [31:0] addr_lo = 32'h0;
  logic [15:0] addr_hi = 16'h0;
  logic [15:0] pause_quanta = 16'h0;
  logic [15:0] holdoff_quanta = 16'h0;
  logic xoff_fifo = 0, xoff_cfg = 0, xoff_pin = 0, xon_cfg = 0, xon_pin = 0;
  logic usr_valid = 0, usr_last = 0;
  logic [7:0] usr_data = 8'h0;
  logic usr_ready, tx_valid, tx_last, tx_pause;
  logic [7:0] tx_data;

  int checks = 0, fails = 0, cyc = 0;
  int pidx = 0, nfr = 0;
  logic [7:0] frm [0:59];
  int starts [0:63];
  bit done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_frame_gen u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) if (rst_n) begin
    if (tx_pause) begin
      if (usr_ready) chk(0, "R6 ready during pause", 1, 0);
      if (!tx_valid) chk(0, "R3 valid gap", 0, 1);
      if (pidx == 0 && nfr < 64) starts[nfr] = cyc;
      if (pidx < 60) frm[pidx] = tx_data;
      if (tx_last) begin
        chk(pidx == 59, "R3 length", pidx + 1, 60);
        pidx = 0;
        nfr++;
      end else begin
        pidx++;
      end
    end
  end

  function automatic logic [7:0] exp_byte(input int i, input bit xoff, input logic [15:0] q);
    logic [47:0] st;
    st = {addr_hi, addr_lo};
    if (i < 6)       return (48'h0180C2000001 >> (8 * (5 - i))) & 48'hFF;
    else if (i < 12) return 8'(st >> (8 * (i - 6)));
    else if (i < 16) return 8'(32'h88080001 >> (8 * (15 - i)));
    else if (i == 16) return xoff ? q[15:8] : 8'h00;
    else if (i == 17) return xoff ? q[7:0] : 8'h00;
    return 8'h00;
  endfunction

  task automatic check_frame(input bit xoff, input logic [15:0] q);
    for (int i = 0; i < 60; i++) begin
      string tag;
      tag = (i < 6) ? "R1 dest" : (i < 12) ? "R2 src" : (i < 16) ? "R3 type/op" :
            (i < 18) ? (xoff ? "R4 xoff quanta" : "R4 xon quanta") : "R5 pad";
      chk(frm[i] == exp_byte(i, xoff, q), tag, frm[i], exp_byte(i, xoff, q));
    end
  endtask

  task automatic wait_frames(input int target, input string req);
    int t;
    t = 0;
    while (nfr < target && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(nfr >= target, req, nfr, target);
  endtask

  task automatic drive(ref logic s, input logic v);
    @(posedge clk); #1 s = v;
  endtask

  task automatic pulse2(ref logic a, ref logic b);
    @(posedge clk); #1 a = 1; b = 1;
    @(posedge clk); #1 a = 0; b = 0;
  endtask

  task automatic pulse(ref logic s);
    @(posedge clk); #1 s = 1;
    @(posedge clk); #1 s = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(tx_valid == 0, "R3 reset tx_valid", tx_valid, 0);
    chk(tx_pause == 0, "R6 reset tx_pause", tx_pause, 0);
    chk(usr_ready == 1, "R6 reset ready", usr_ready, 1);

    // R7 and R1..R5: sweep of addresses/quanta across the three XOFF sources
    for (int k = 0; k < 6; k++) begin
      addr_lo = 32'h1234_5678 ^ (32'h1111_1111 * k);
      addr_hi = 16'hABCD + 16'(k * 257);
      pause_quanta = 16'(16'h0001 << (2 * k)) ^ 16'(k * 16'h0F31);
      base = nfr;
      case (k % 3)
        0: pulse(xoff_pin);
        1: pulse(xoff_cfg);
        default: pulse(xoff_fifo);
      endcase
      wait_frames(base + 1, "R7 xoff source");
      chk(nfr == base + 1, "R7 single frame", nfr - base, 1);
      check_frame(1, pause_quanta);
      idle(5);
    end

    // R8: XON from both sources
    base = nfr; pulse(xon_cfg);
    wait_frames(base + 1, "R8 xon cfg"); check_frame(0, pause_quanta); idle(5);
    base = nfr; pulse(xon_pin);
    wait_frames(base + 1, "R8 xon pin"); check_frame(0, pause_quanta); idle(5);

    // R9: XON and XOFF in the same cycle
    pause_quanta = 16'hBEEF;
    base = nfr; pulse2(xon_pin, xoff_cfg);
    wait_frames(base + 1, "R9 xoff wins");
    chk(frm[16] == 8'hBE && frm[17] == 8'hEF, "R9 quanta", {frm[16], frm[17]}, 16'hBEEF);
    idle(70);
    chk(nfr == base + 1, "R9 one frame", nfr - base, 1);

    // R6: request during a user frame waits for its end
    base = nfr;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1;
      usr_valid = 1; usr_data = 8'(8'h40 + i); usr_last = (i == 19);
      xoff_pin = (i == 5);
      @(negedge clk);
      chk(usr_ready && tx_valid && !tx_pause && tx_data == usr_data, "R6 user pass", tx_data, usr_data);
      chk(tx_last == (i == 19), "R6 user last", tx_last, i == 19);
    end
    @(posedge clk); #1 usr_valid = 0; usr_last = 0; xoff_pin = 0;
    chk(nfr == base, "R6 no pause inside user frame", nfr - base, 0);
    wait_frames(base + 1, "R6 held request sent");
    check_frame(1, pause_quanta);
    idle(5);

    // R11: disabled function drops requests and pending state
    base = nfr;
    @(posedge clk); #1 usr_valid = 1; usr_data = 8'h11; usr_last = 0;
    @(posedge clk); #1 xoff_pin = 1;
    @(posedge clk); #1 xoff_pin = 0; fc_enable = 0;
    @(posedge clk); #1 usr_last = 1;
    @(posedge clk); #1 usr_valid = 0; usr_last = 0;
    pulse(xoff_cfg); pulse(xon_cfg); pulse(xoff_fifo); pulse(xon_pin);
    idle(100);
    chk(nfr == base, "R11 disabled no frame", nfr - base, 0);
    drive(fc_enable, 1);
    idle(100);
    chk(nfr == base, "R11 pending dropped", nfr - base, 0);

    // R10: holdoff spacing with a level-held source
    for (int h = 0; h < 4; h++) begin
      int lo, hi, g;
      holdoff_quanta = 16'(h);
      lo = (h * 64 > 60) ? h * 64 : 60;
      hi = (h * 64 + 2 > 61) ? h * 64 + 2 : 61;
      base = nfr;
      drive(xoff_fifo, 1);
      wait_frames(base + 3, "R10 repeated xoff");
      drive(xoff_fifo, 0);
      for (int j = 0; j < 2; j++) begin
        g = starts[base + j + 1] - starts[base + j];
        chk(g >= lo && g <= hi, "R10 holdoff gap", g, lo);
      end
      idle(300);
    end

    // R10: pulse during holdoff is dropped
    holdoff_quanta = 16'd4;
    base = nfr; pulse(xoff_pin);
    wait_frames(base + 1, "R10 first xoff");
    pulse(xoff_cfg);
    idle(200);
    chk(nfr == base + 1, "R10 request in holdoff dropped", nfr - base, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule